// File: doc/BRIEF.md
# Dual-Stage Min/Max Execution Unit

This unit executes a two-step integer selection instruction. A 64-bit instruction word steers it, and three 32-bit register operands A, B and C feed it. The first step picks either the smaller or the larger of A and B. The comparison treats A and B either as signed or as unsigned numbers. The second step then combines that pick with C in one of eight ways. It can write the pick into one halfword or byte lane of C and leave the rest of C as it was. It can add the pick to C. It can take a further minimum or maximum against C, with a signedness of its own. It can also return the pick unchanged.

The unit sits in an execution pipeline behind the instruction decoder. It has one register stage: a word presented with its valid strobe gives a result, an error flag and an output strobe on the next clock. Some control settings have no implementation here: saturation, an immediate B operand, sub-32-bit source formats, and mixed A/B signedness. Any of these raises the unsupported flag and forces the result to zero.

Top module: `dmm_unit`

## Requirements
- R1: The output strobe `out_valid` is high in the cycle after each cycle in which `in_valid` is high, and low otherwise. A synchronous active-high reset clears it.
- R2: Instruction bit 56 selects the first step: 1 takes the larger of A and B, 0 the smaller.
- R3: Instruction bit 48 set makes the first-step comparison two's-complement signed. Clear makes it unsigned.
- R4: Second-step codes in bits 53:51 select a lane merge. Code 0 replaces C[31:16] with the low 16 bits of the first-step value. Code 1 replaces C[15:0] with them. Code 2 replaces C[7:0] with its low 8 bits. Code 3 replaces C[23:16] with its low 8 bits. Every other bit of C passes through.
- R5: Code 4 returns the first-step value plus C, modulo 2^32.
- R6: Codes 5 and 6 return the minimum (5) or maximum (6) of the first-step value and C. The comparison is signed when bit 54 is set and unsigned when it is clear.
- R7: Code 7 returns the first-step value unchanged.
- R8: `out_unsup` is raised and `out_result` is zero when any of these holds: bit 55 (saturate) is 1; bit 50 (B from register) is 0; bits 38:37 (A format) or bits 30:29 (B format) are anything other than 0b11, which is the 32-bit encoding (0b10 is 16-bit, all else 8-bit); bits 48 and 49 differ.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Instruction and operands are valid this cycle |
| insn | input | 64 | Instruction word |
| opnd_a | input | 32 | Operand A |
| opnd_b | input | 32 | Operand B |
| opnd_c | input | 32 | Operand C |
| out_valid | output | 1 | Result valid, one cycle after `in_valid` |
| out_result | output | 32 | Second-step result, zero when unsupported |
| out_unsup | output | 1 | Unsupported control setting detected |

## Verification
The two steps always act in the same cycle, so their signedness controls can disagree. A word that asks for an unsigned first step and a signed second step, or the reverse, shows whether each step reads its own bit. The bench drives the boundary values 0x80000000, 0x7FFFFFFF and 0xFFFFFFFF under both signedness settings to provoke this. An unsupported setting can also arrive together with any second-step code, and the zeroed result must win over the merge or add. The bench issues such words back to back with legal ones and compares every cycle against its behavioural model.

// File: rtl/dmm_pkg.sv
package dmm_pkg;
   // Control field positions (decoded by the instruction word producer)
   localparam int BIT_FIRST_MAX  = 56;
   localparam int BIT_SAT        = 55;
   localparam int BIT_SEC_SIGNED = 54;
   localparam int OP_HI          = 53;
   localparam int OP_LO          = 51;
   localparam int BIT_B_REG      = 50;
   localparam int BIT_B_SIGNED   = 49;
   localparam int BIT_A_SIGNED   = 48;
   localparam int FMT_A_HI       = 38;
   localparam int FMT_A_LO       = 37;
   localparam int FMT_B_HI       = 30;
   localparam int FMT_B_LO       = 29;
   localparam logic [1:0] FMT_WORD = 2'b11;

   typedef enum logic [2:0] {
      SEC_MRG_HI  = 3'd0,
      SEC_MRG_LO  = 3'd1,
      SEC_MRG_B0  = 3'd2,
      SEC_MRG_B2  = 3'd3,
      SEC_ACC     = 3'd4,
      SEC_MIN     = 3'd5,
      SEC_MAX     = 3'd6,
      SEC_PASS    = 3'd7
   } sec_op_e;

   typedef struct packed {
      logic    first_max;
      logic    first_signed;
      logic    sec_signed;
      sec_op_e op;
      logic    unsup;
   } ctl_t;
endpackage

// File: rtl/dmm_decode.sv
module dmm_decode
   import dmm_pkg::*;
#(
   parameter int INSN_W = 64
) (
   input  logic [INSN_W-1:0] insn,
   output ctl_t              ctl
);
   if (INSN_W <= BIT_FIRST_MAX) begin : g_chk_w
      $error("dmm_decode: INSN_W too narrow for control fields");
   end

   logic fmt_a_bad, fmt_b_bad, sign_mix;

   always_comb begin
      fmt_a_bad = (insn[FMT_A_HI:FMT_A_LO] != FMT_WORD);
      fmt_b_bad = (insn[FMT_B_HI:FMT_B_LO] != FMT_WORD);
      sign_mix  = insn[BIT_A_SIGNED] ^ insn[BIT_B_SIGNED];
      ctl.first_max    = insn[BIT_FIRST_MAX];
      ctl.first_signed = insn[BIT_A_SIGNED];
      ctl.sec_signed   = insn[BIT_SEC_SIGNED];
      ctl.op           = sec_op_e'(insn[OP_HI:OP_LO]);
      ctl.unsup        = insn[BIT_SAT] | ~insn[BIT_B_REG] | fmt_a_bad
                         | fmt_b_bad | sign_mix;
   end
endmodule

// File: rtl/dmm_stage1.sv
module dmm_stage1 #(
   parameter int W = 32
) (
   input  logic [W-1:0] a,
   input  logic [W-1:0] b,
   input  logic         take_max,
   input  logic         is_signed,
   output logic [W-1:0] res
);
   logic a_lt_b;

   always_comb begin
      // flip the sign bits so one unsigned comparator serves both modes
      a_lt_b = {a[W-1] ^ is_signed, a[W-2:0]} < {b[W-1] ^ is_signed, b[W-2:0]};
      res    = (a_lt_b ^ take_max) ? a : b;
   end
endmodule

// File: rtl/dmm_stage2.sv
module dmm_stage2
   import dmm_pkg::*;
#(
   parameter int W    = 32,
   parameter int BYTE = 8
) (
   input  logic [W-1:0] s1,
   input  logic [W-1:0] c,
   input  sec_op_e      op,
   input  logic         is_signed,
   output logic [W-1:0] res
);
   localparam int HALF   = W / 2;
   localparam int NLANES = 4;

   function automatic int lane_off(int k);
      return (k == 0 || k == 3) ? HALF : 0;
   endfunction
   function automatic int lane_wid(int k);
      return (k < 2) ? HALF : BYTE;
   endfunction

   logic [W-1:0] merged [NLANES];

   for (genvar k = 0; k < NLANES; k++) begin : g_lane
      localparam int OFF = lane_off(k);
      localparam int WID = lane_wid(k);
      localparam logic [W-1:0] MASK = ((W'(1) << WID) - W'(1)) << OFF;
      assign merged[k] = (c & ~MASK) | ((s1 << OFF) & MASK);
   end

   logic s1_lt_c;

   always_comb begin
      s1_lt_c = {s1[W-1] ^ is_signed, s1[W-2:0]} < {c[W-1] ^ is_signed, c[W-2:0]};
      unique case (op)
         SEC_MRG_HI: res = merged[0];
         SEC_MRG_LO: res = merged[1];
         SEC_MRG_B0: res = merged[2];
         SEC_MRG_B2: res = merged[3];
         SEC_ACC:    res = s1 + c;
         SEC_MIN:    res = s1_lt_c ? s1 : c;
         SEC_MAX:    res = s1_lt_c ? c : s1;
         default:    res = s1;
      endcase
   end
endmodule

// File: rtl/dmm_unit.sv
module dmm_unit
   import dmm_pkg::*;
#(
   parameter int DATA_W = 32,
   parameter int INSN_W = 64
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              in_valid,
   input  logic [INSN_W-1:0] insn,
   input  logic [DATA_W-1:0] opnd_a,
   input  logic [DATA_W-1:0] opnd_b,
   input  logic [DATA_W-1:0] opnd_c,
   output logic              out_valid,
   output logic [DATA_W-1:0] out_result,
   output logic              out_unsup
);
   localparam int BYTE_W = 8;

   if (DATA_W % 2 != 0 || DATA_W < 3 * BYTE_W) begin : g_chk_data
      $error("dmm_unit: DATA_W must be even and hold the upper byte lane");
   end

   ctl_t              ctl;
   logic [DATA_W-1:0] s1_val, s2_val;

   dmm_decode #(.INSN_W(INSN_W)) u_dec (.insn(insn), .ctl(ctl));

   dmm_stage1 #(.W(DATA_W)) u_s1 (
      .a(opnd_a), .b(opnd_b), .take_max(ctl.first_max),
      .is_signed(ctl.first_signed), .res(s1_val));

   dmm_stage2 #(.W(DATA_W), .BYTE(BYTE_W)) u_s2 (
      .s1(s1_val), .c(opnd_c), .op(ctl.op),
      .is_signed(ctl.sec_signed), .res(s2_val));

   always_ff @(posedge clk) begin
      if (rst) begin
         out_valid  <= 1'b0;
         out_result <= '0;
         out_unsup  <= 1'b0;
      end else begin
         out_valid <= in_valid;
         if (in_valid) begin
            out_unsup  <= ctl.unsup;
            out_result <= ctl.unsup ? '0 : s2_val;
         end
      end
   end

   a_r1_valid_follows: assert property (@(posedge clk) disable iff (rst)
      in_valid |=> out_valid);
   a_r1_idle_quiet: assert property (@(posedge clk) disable iff (rst)
      !in_valid |=> !out_valid);
   a_r8_zero_on_unsup: assert property (@(posedge clk) disable iff (rst)
      (out_valid && out_unsup) |-> (out_result == '0));
   a_r2_pick_is_operand: assert property (@(posedge clk) disable iff (rst)
      in_valid |-> (s1_val == opnd_a || s1_val == opnd_b));
   a_r4_hi_keeps_low: assert property (@(posedge clk) disable iff (rst)
      (in_valid && !ctl.unsup && ctl.op == SEC_MRG_HI)
      |=> (out_result[DATA_W/2-1:0] == $past(opnd_c[DATA_W/2-1:0])));
   a_r4_b0_keeps_upper: assert property (@(posedge clk) disable iff (rst)
      (in_valid && !ctl.unsup && ctl.op == SEC_MRG_B0)
      |=> (out_result[DATA_W-1:BYTE_W] == $past(opnd_c[DATA_W-1:BYTE_W])));
   a_r6_umax_not_below_c: assert property (@(posedge clk) disable iff (rst)
      (in_valid && !ctl.unsup && ctl.op == SEC_MAX && !ctl.sec_signed)
      |=> (out_result >= $past(opnd_c)));
   a_r7_pass_first: assert property (@(posedge clk) disable iff (rst)
      (in_valid && !ctl.unsup && ctl.op == SEC_PASS)
      |=> (out_result == $past(s1_val)));
endmodule

// File: tb/dmm_unit_bench.sv
module dmm_unit_bench;
   logic        clk = 1'b0;
   logic        rst = 1'b1;
   logic        in_valid = 1'b0;
   logic [63:0] insn = '0;
   logic [31:0] opnd_a = '0, opnd_b = '0, opnd_c = '0;
   logic        out_valid, out_unsup;
   logic [31:0] out_result;

   int n_checks = 0;
   int n_fail   = 0;

   // expected outputs for the next sample
   bit          pend_valid = 0;
   bit          pend_err   = 0;
   logic [31:0] pend_res   = '0;
   string       pend_tag   = "R1";

   always #4 clk = ~clk;   // 125 MHz

   dmm_unit u_dmm_unit (
      .clk(clk), .rst(rst), .in_valid(in_valid), .insn(insn),
      .opnd_a(opnd_a), .opnd_b(opnd_b), .opnd_c(opnd_c),
      .out_valid(out_valid), .out_result(out_result), .out_unsup(out_unsup));

   function automatic logic [63:0] mk(bit mx, bit sa, bit sb, bit sd, int op,
                                      int fa = 3, int fb = 3, bit sat = 0, bit breg = 1);
      logic [63:0] w = '0;
      w[56] = mx; w[55] = sat; w[54] = sd; w[53:51] = op[2:0];
      w[50] = breg; w[49] = sb; w[48] = sa;
      w[38:37] = fa[1:0]; w[30:29] = fb[1:0];
      return w;
   endfunction

   function automatic longint num(logic [31:0] v, bit sgn);
      return sgn ? longint'($signed(v)) : longint'({32'd0, v});
   endfunction

   function automatic logic [31:0] model(logic [63:0] w, logic [31:0] a, logic [31:0] b,
                                         logic [31:0] c, output bit err);
      longint na, nb, f, nc;
      logic [31:0] first, r;
      err = w[55] || !w[50] || (w[38:37] != 2'b11) || (w[30:29] != 2'b11) || (w[48] != w[49]);
      na = num(a, w[48]); nb = num(b, w[48]);
      if (w[56]) f = (na > nb) ? na : nb;
      else       f = (na < nb) ? na : nb;
      first = f[31:0];
      f  = num(first, w[54]);
      nc = num(c, w[54]);
      r = c;
      case (int'(w[53:51]))
         0: r[31:16] = first[15:0];
         1: r[15:0]  = first[15:0];
         2: r[7:0]   = first[7:0];
         3: r[23:16] = first[7:0];
         4: r = first + c;
         5: r = (f < nc) ? first : c;
         6: r = (f > nc) ? first : c;
         default: r = first;
      endcase
      return err ? 32'd0 : r;
   endfunction

   task automatic check(bit ok, string tag, string what, longint act, longint exp);
      n_checks++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
      end
   endtask

   // sample last result, then present a new word (or an idle cycle)
   task automatic step(bit v, logic [63:0] w, logic [31:0] a, logic [31:0] b,
                       logic [31:0] c, string tag);
      bit e;
      @(negedge clk);
      check(out_valid == pend_valid, "R1", "out_valid", out_valid, pend_valid);
      if (pend_valid) begin
         check(out_unsup == pend_err, pend_err ? "R8" : pend_tag, "out_unsup",
               out_unsup, pend_err);
         check(out_result == pend_res, pend_err ? "R8" : pend_tag, "out_result",
               out_result, pend_res);
      end
      in_valid = v; insn = w; opnd_a = a; opnd_b = b; opnd_c = c;
      pend_valid = v;
      pend_res   = model(w, a, b, c, e);
      pend_err   = e;
      pend_tag   = tag;
   endtask

   function automatic string op_tag(int op);
      if (op < 4) return "R4";
      if (op == 4) return "R5";
      if (op < 7) return "R6";
      return "R7";
   endfunction

   initial begin : watchdog
      repeat (150000) @(posedge clk);
      n_checks++; n_fail++;
      $display("FAIL watchdog expired actual=hung expected=done");
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
   end

   initial begin : main
      logic [31:0] corner [6] = '{32'h0, 32'h1, 32'h7FFFFFFF, 32'h80000000,
                                  32'hFFFFFFFF, 32'h12345678};
      repeat (3) @(negedge clk);
      // R1: reset state
      check(out_valid == 1'b0, "R1", "out_valid in reset", out_valid, 0);
      @(negedge clk); rst = 1'b0;

      // R2 / R3: first step alone through the pass code
      step(1, mk(1, 1, 1, 0, 7), 32'h80000000, 32'h7FFFFFFF, 0, "R2");
      step(1, mk(0, 1, 1, 0, 7), 32'h80000000, 32'h7FFFFFFF, 0, "R3");
      step(1, mk(1, 0, 0, 0, 7), 32'h80000000, 32'h7FFFFFFF, 0, "R3");
      step(1, mk(0, 0, 0, 0, 7), 32'hFFFFFFFF, 32'h00000001, 0, "R2");
      step(0, '0, 0, 0, 0, "R1");
      // R4: lanes
      step(1, mk(1, 0, 0, 0, 0), 32'h0000ABCD, 32'h1, 32'h11223344, "R4");
      step(1, mk(1, 0, 0, 0, 1), 32'h0000ABCD, 32'h1, 32'h11223344, "R4");
      step(1, mk(1, 0, 0, 0, 2), 32'h0000ABCD, 32'h1, 32'h11223344, "R4");
      step(1, mk(1, 0, 0, 0, 3), 32'h0000ABCD, 32'h1, 32'h11223344, "R4");
      // R5: wraparound
      step(1, mk(1, 0, 0, 0, 4), 32'hFFFFFFFF, 32'h0, 32'h2, "R5");
      // R6: mixed signedness between steps
      step(1, mk(1, 0, 0, 1, 6), 32'h80000000, 32'h1, 32'h7FFFFFFF, "R6");
      step(1, mk(1, 1, 1, 0, 5), 32'hFFFFFFFF, 32'h1, 32'h80000000, "R6");
      // R8: each unsupported cause, next to legal words
      step(1, mk(1, 0, 0, 0, 4, 3, 3, 1, 1), 5, 6, 7, "R8");
      step(1, mk(1, 0, 0, 0, 4, 3, 3, 0, 0), 5, 6, 7, "R8");
      step(1, mk(1, 0, 0, 0, 0, 2, 3), 5, 6, 7, "R8");
      step(1, mk(1, 0, 0, 0, 1, 3, 0), 5, 6, 7, "R8");
      step(1, mk(1, 1, 0, 0, 7), 5, 6, 7, "R8");
      step(1, mk(1, 0, 0, 0, 7), 5, 6, 7, "R7");

      // corner sweep over every code, both modes
      for (int op = 0; op < 8; op++)
         for (int m = 0; m < 4; m++)
            for (int i = 0; i < 6; i++)
               for (int j = 0; j < 6; j++)
                  step(1, mk(m[0], m[1], m[1], m[0] ^ m[1], op), corner[i], corner[j],
                       corner[(i + j + op) % 6], op_tag(op));

      // random words, including unsupported ones and idle gaps
      for (int k = 0; k < 3000; k++) begin
         int op = $urandom_range(0, 7);
         bit s  = 1'($urandom);
         bit bad = ($urandom_range(0, 9) == 0);
         logic [63:0] w = mk(1'($urandom), s, s, 1'($urandom), op);
         if (bad) w[55] = 1'b1;
         step(($urandom_range(0, 7) != 0), w, $urandom, $urandom, $urandom,
              bad ? "R8" : op_tag(op));
      end
      step(0, '0, 0, 0, 0, "R1");
      step(0, '0, 0, 0, 0, "R1");

      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
   end
endmodule